// File: doc/BRIEF.md
# Accumulator ALU with Five-Flag Update

This block is the arithmetic and logic unit of a small accumulator-style processor. The sequencer gives it an operation code, the accumulator byte, a second operand byte and the current flag vector. One clock later the block returns the result byte, a complete next flag vector and a per-flag write-enable mask. The register file uses the mask to decide which flag bits it stores. Operand fetch, instruction decode and register storage are handled elsewhere.

The operations are binary add, add with carry, subtract, subtract with borrow, compare, AND, XOR, OR, increment, decrement, the four rotates (two circular, two through carry), accumulator complement, set carry, complement carry and a two-step decimal adjust for packed BCD. The result is computed combinationally and captured in one output register stage. A valid strobe goes with each result.

The flag vector has the same layout on input and output: bit 0 carry, bit 1 auxiliary carry (the carry or borrow between the nibbles), bit 2 parity, bit 3 zero, bit 4 sign. Any flag bit that an operation does not write is copied from the input to the output unchanged.

Top module: `acc_alu8`

## Requirements
- R1: While rst_n is low, and afterwards until the first accepted operation, res_valid, result, flags_out and flags_we are all zero.
- R2: An operation presented with op_valid high on a rising clock edge produces res_valid high on the following cycle. A cycle with op_valid low gives res_valid low and flags_we zero on the following cycle, and result keeps its previous value.
- R3: Add (op 0) and add with carry (op 1, which also adds flags_in[0]) return the low 8 bits of the sum. Carry is the carry out of bit 7 and auxiliary carry is the carry out of bit 3. All five flags are written (flags_we = 5'b11111).
- R4: Subtract (op 2) and subtract with borrow (op 3, which also subtracts flags_in[0]) return the low 8 bits of the difference. Carry is 1 when the unsigned subtrahend plus borrow-in exceeds the accumulator. Auxiliary carry is 1 when the subtrahend's low nibble plus borrow-in exceeds the accumulator's low nibble. All five flags are written.
- R5: Compare (op 7) sets all five flags exactly as subtract does, and its result output equals the unchanged accumulator.
- R6: AND (op 4), XOR (op 5) and OR (op 6) return the bitwise result, clear carry and auxiliary carry, and write all five flags.
- R7: Increment (op 8) and decrement (op 9) return the accumulator plus or minus one (mod 256). They write zero, sign, parity and auxiliary carry (flags_we = 5'b11110). Auxiliary carry is 1 when the low nibble was 0xF for increment or 0x0 for decrement. Carry is not written and passes through.
- R8: Rotate-left-circular (op 10) moves bit 7 into bit 0 and into carry. Rotate-right-circular (op 11) moves bit 0 into bit 7 and into carry. Only carry is written (flags_we = 5'b00001).
- R9: Rotate-left-through-carry (op 12) puts the old carry into bit 0 and bit 7 into carry. Rotate-right-through-carry (op 13) puts the old carry into bit 7 and bit 0 into carry. Only carry is written.
- R10: Complement (op 14) returns the bitwise inverse of the accumulator and writes no flag.
- R11: Set-carry (op 15) forces carry to 1 and complement-carry (op 16) inverts carry. Both write only carry and return the accumulator unchanged.
- R12: Decimal adjust (op 17) first adds 6 when the low nibble is above 9 or auxiliary carry is set. It then adds 0x60 when the high nibble of that sum is above 9, carry is set, or the first addition overflowed 8 bits. Auxiliary carry becomes 1 exactly when the original low nibble is above 9. Carry becomes 1 if it was already set or if either addition overflowed 8 bits. All five flags are written.
- R13: Op codes 18 to 31 return the accumulator unchanged and write no flag.
- R14: Whenever a flag is written: zero is 1 for a 0x00 result, sign is result bit 7, and parity is 1 for an even number of one bits. Compare takes these three from the discarded difference. Every unwritten flag bit in flags_out equals the matching bit of flags_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op | input | 5 | Operation code (see requirements) |
| acc | input | 8 | Accumulator operand |
| operand | input | 8 | Second operand byte |
| flags_in | input | 5 | Current flags {sign, zero, parity, aux, carry} |
| res_valid | output | 1 | Registered result valid |
| result | output | 8 | Result byte |
| flags_out | output | 5 | Next flag vector, same layout as flags_in |
| flags_we | output | 5 | Per-flag write enable, same layout |

## Verification
The hardest paths to reach are in decimal adjust. The first +6 can overflow 8 bits only for accumulators of 0xFA and above with the low-nibble fix active. An auxiliary carry coming in with a low nibble of 9 or less has to be combined with both values of the incoming carry. Uniform random bytes seldom land on these, so the stimulus adds directed decimal-adjust cases that sweep high accumulators and every pair of incoming carry and auxiliary carry. It also includes the nibble-boundary cases for add, subtract, increment and decrement, 0x0F/0xF0 and 0x00/0xFF. The rest is random operations over all 32 codes, including unassigned ones and idle gaps.

// File: rtl/acc_alu8.sv
module acc_alu8 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [4:0] op,
  input  logic [7:0] acc,
  input  logic [7:0] operand,
  input  logic [4:0] flags_in,
  output logic       res_valid,
  output logic [7:0] result,
  output logic [4:0] flags_out,
  output logic [4:0] flags_we
);

  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3;
  localparam logic [4:0] OP_AND = 5'd4,  OP_XOR = 5'd5,  OP_OR  = 5'd6,  OP_CMP = 5'd7;
  localparam logic [4:0] OP_INC = 5'd8,  OP_DEC = 5'd9,  OP_RLC = 5'd10, OP_RRC = 5'd11;
  localparam logic [4:0] OP_RAL = 5'd12, OP_RAR = 5'd13, OP_CPL = 5'd14, OP_SCF = 5'd15;
  localparam logic [4:0] OP_CCF = 5'd16, OP_DAA = 5'd17;

  wire fc = flags_in[0];
  wire fa = flags_in[1];

  logic [7:0] r, fr;
  logic       cy, ac, cin, lo_fix, hi_fix;
  logic [4:0] we;
  logic [8:0] s9, t9, u9;
  logic [4:0] s5;

  always_comb begin
    r = acc; fr = acc; cy = fc; ac = fa; we = 5'b00000;
    cin = 1'b0; s9 = '0; s5 = '0; t9 = '0; u9 = '0; lo_fix = 1'b0; hi_fix = 1'b0;
    case (op)
      OP_ADD, OP_ADC: begin
        cin = (op == OP_ADC) & fc;
        s9  = {1'b0, acc} + {1'b0, operand} + {8'd0, cin};
        s5  = {1'b0, acc[3:0]} + {1'b0, operand[3:0]} + {4'd0, cin};
        r = s9[7:0]; fr = s9[7:0]; cy = s9[8]; ac = s5[4]; we = 5'b11111;
      end
      OP_SUB, OP_SBB, OP_CMP: begin
        cin = (op == OP_SBB) & fc;
        s9  = {1'b0, acc} - {1'b0, operand} - {8'd0, cin};
        s5  = {1'b0, acc[3:0]} - {1'b0, operand[3:0]} - {4'd0, cin};
        r  = (op == OP_CMP) ? acc : s9[7:0];
        fr = s9[7:0]; cy = s9[8]; ac = s5[4]; we = 5'b11111;
      end
      OP_AND: begin r = acc & operand; fr = r; cy = 1'b0; ac = 1'b0; we = 5'b11111; end
      OP_XOR: begin r = acc ^ operand; fr = r; cy = 1'b0; ac = 1'b0; we = 5'b11111; end
      OP_OR:  begin r = acc | operand; fr = r; cy = 1'b0; ac = 1'b0; we = 5'b11111; end
      OP_INC: begin r = acc + 8'd1; fr = r; ac = (acc[3:0] == 4'hF); we = 5'b11110; end
      OP_DEC: begin r = acc - 8'd1; fr = r; ac = (acc[3:0] == 4'h0); we = 5'b11110; end
      OP_RLC: begin r = {acc[6:0], acc[7]}; cy = acc[7]; we = 5'b00001; end
      OP_RRC: begin r = {acc[0], acc[7:1]}; cy = acc[0]; we = 5'b00001; end
      OP_RAL: begin r = {acc[6:0], fc};     cy = acc[7]; we = 5'b00001; end
      OP_RAR: begin r = {fc, acc[7:1]};     cy = acc[0]; we = 5'b00001; end
      OP_CPL: r = ~acc;
      OP_SCF: begin cy = 1'b1; we = 5'b00001; end
      OP_CCF: begin cy = ~fc;  we = 5'b00001; end
      OP_DAA: begin
        lo_fix = (acc[3:0] > 4'd9) | fa;
        t9 = {1'b0, acc} + (lo_fix ? 9'h006 : 9'h000);
        hi_fix = (t9[7:4] > 4'd9) | fc | t9[8];
        u9 = {1'b0, t9[7:0]} + (hi_fix ? 9'h060 : 9'h000);
        r = u9[7:0]; fr = r;
        ac = (acc[3:0] > 4'd9);
        cy = fc | t9[8] | u9[8];
        we = 5'b11111;
      end
      default: ;
    endcase
  end

  wire [4:0] calc = {fr[7], (fr == 8'h00), ~^fr, ac, cy};
  wire [4:0] nxt  = (calc & we) | (flags_in & ~we);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      result    <= 8'h00;
      flags_out <= 5'b00000;
      flags_we  <= 5'b00000;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        result    <= r;
        flags_out <= nxt;
        flags_we  <= we;
      end else begin
        flags_we  <= 5'b00000;
      end
    end
  end

  assert_idle_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> flags_we == 5'b00000);

  assert_cmp_keeps_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && $past(op) == OP_CMP |-> result == $past(acc) && flags_we == 5'b11111);

  assert_incdec_keeps_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && ($past(op) == OP_INC || $past(op) == OP_DEC)
      |-> !flags_we[0] && flags_out[0] == $past(flags_in[0]));

  assert_rotate_carry_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && $past(op) >= OP_RLC && $past(op) <= OP_RAR |-> flags_we == 5'b00001);

  assert_cpl_no_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && $past(op) == OP_CPL |-> result == ~$past(acc) && flags_we == 5'b00000);

  assert_scf_sets_carry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && $past(op) == OP_SCF |-> flags_out[0] && result == $past(acc));

  assert_spare_codes_R13: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && $past(op) > OP_DAA |-> flags_we == 5'b00000 && result == $past(acc));

endmodule

// File: tb/test_acc_alu8.sv
`timescale 1ns/1ps
module test_acc_alu8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] acc = '0, operand = '0;
  logic [4:0] flags_in = '0;
  logic       res_valid;
  logic [7:0] result;
  logic [4:0] flags_out, flags_we;

  int checks = 0;
  int fails  = 0;
  logic [7:0] last_result = '0;

  always #4 clk = ~clk;

  acc_alu8 i_acc_alu8 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .acc(acc),
    .operand(operand), .flags_in(flags_in), .res_valid(res_valid),
    .result(result), .flags_out(flags_out), .flags_we(flags_we)
  );

  function automatic string tag_of(input logic [4:0] o);
    if (o <= 1) return "R3";
    if (o == 2 || o == 3) return "R4";
    if (o == 7) return "R5";
    if (o >= 4 && o <= 6) return "R6";
    if (o == 8 || o == 9) return "R7";
    if (o == 10 || o == 11) return "R8";
    if (o == 12 || o == 13) return "R9";
    if (o == 14) return "R10";
    if (o == 15 || o == 16) return "R11";
    if (o == 17) return "R12";
    return "R13";
  endfunction

  // returns {we[4:0], flags[4:0], result[7:0]}
  function automatic logic [17:0] model(input logic [4:0] o, input logic [7:0] a,
                                        input logic [7:0] b, input logic [4:0] f);
    int ai = a, bi = b, c = f[0], x = 0, basis;
    logic [7:0] res = a;
    logic cyo = f[0], aco = f[1];
    logic [4:0] w = 0, fl;
    case (o)
      0, 1: begin
        if (o == 0) c = 0;
        x = ai + bi + c; res = x[7:0]; cyo = (x > 255);
        aco = ((ai % 16) + (bi % 16) + c) > 15; w = 5'b11111;
      end
      2, 3, 7: begin
        if (o != 3) c = 0;
        x = ai - bi - c; res = x[7:0]; cyo = (bi + c) > ai;
        aco = ((bi % 16) + c) > (ai % 16); w = 5'b11111;
      end
      4: begin res = a & b; cyo = 0; aco = 0; w = 5'b11111; end
      5: begin res = a ^ b; cyo = 0; aco = 0; w = 5'b11111; end
      6: begin res = a | b; cyo = 0; aco = 0; w = 5'b11111; end
      8: begin res = 8'((ai + 1) % 256);   aco = (ai % 16) == 15; w = 5'b11110; end
      9: begin res = 8'((ai + 255) % 256); aco = (ai % 16) == 0;  w = 5'b11110; end
      10: begin res = 8'((ai * 2) % 256 + ai / 128); cyo = a[7]; w = 1; end
      11: begin res = 8'(ai / 2 + (ai % 2) * 128);   cyo = a[0]; w = 1; end
      12: begin res = 8'((ai * 2) % 256 + c);        cyo = a[7]; w = 1; end
      13: begin res = 8'(ai / 2 + c * 128);          cyo = a[0]; w = 1; end
      14: res = 8'(255 - ai);
      15: begin cyo = 1; w = 1; end
      16: begin cyo = !f[0]; w = 1; end
      17: begin
        x = ai;
        if ((ai % 16) > 9 || f[1]) x = x + 6;
        cyo = f[0] || x > 255;
        x = x % 256;
        if ((x / 16) > 9 || cyo) x = x + 96;
        if (x > 255) cyo = 1;
        res = x[7:0]; aco = (ai % 16) > 9; w = 5'b11111;
      end
      default: ;
    endcase
    basis = res;
    if (o == 7) basis = (ai - bi + 256) % 256;
    fl[0] = w[0] ? cyo : f[0];
    fl[1] = w[1] ? aco : f[1];
    fl[2] = w[2] ? ($countones(8'(basis)) % 2 == 0) : f[2];
    fl[3] = w[3] ? (basis == 0) : f[3];
    fl[4] = w[4] ? (basis >= 128) : f[4];
    if (o == 7) res = a;
    return {w, fl, res};
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [4:0] o, input logic [7:0] a, input logic [7:0] b,
                        input logic [4:0] f);
    logic [17:0] e;
    string t;
    e = model(o, a, b, f);
    t = tag_of(o);
    @(negedge clk);
    op_valid = 1'b1; op = o; acc = a; operand = b; flags_in = f;
    @(negedge clk);
    op_valid = 1'b0;
    check("R2", "res_valid", res_valid, 1);
    check(t, "result", result, e[7:0]);
    check(t, "flags_out (R14)", flags_out, e[12:8]);
    check(t, "flags_we", flags_we, e[17:13]);
    last_result = result;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    op_valid = 1'b0; op = 5'($urandom_range(0, 31)); acc = 8'($urandom);
    @(negedge clk);
    check("R2", "res_valid idle", res_valid, 0);
    check("R2", "flags_we idle", flags_we, 0);
    check("R2", "result held", result, last_result);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", "res_valid in reset", res_valid, 0);
    check("R1", "result in reset", result, 0);
    check("R1", "flags_out in reset", flags_out, 0);
    check("R1", "flags_we in reset", flags_we, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1", "res_valid after reset", res_valid, 0);
    check("R1", "flags_we after reset", flags_we, 0);

    run_op(0, 8'hFF, 8'h01, 5'b00000);
    run_op(1, 8'h0F, 8'h00, 5'b00001);
    run_op(2, 8'h00, 8'h01, 5'b00000);
    run_op(3, 8'h10, 8'h00, 5'b00001);
    run_op(7, 8'h42, 8'h42, 5'b10101);
    run_op(7, 8'h01, 8'h80, 5'b00000);
    run_op(4, 8'hF0, 8'h0F, 5'b00011);
    run_op(8, 8'hFF, 8'h00, 5'b00001);
    run_op(9, 8'h00, 8'h00, 5'b00000);
    run_op(10, 8'h81, 8'h00, 5'b00000);
    run_op(11, 8'h01, 8'h00, 5'b00000);
    run_op(12, 8'h80, 8'h00, 5'b00001);
    run_op(13, 8'h01, 8'h00, 5'b00000);
    run_op(14, 8'h5A, 8'h00, 5'b11111);
    run_op(15, 8'h33, 8'h00, 5'b00000);
    run_op(16, 8'h33, 8'h00, 5'b00001);
    run_op(20, 8'h77, 8'h11, 5'b01010);
    idle_cycle();
    for (int a = 0; a < 256; a += 5)
      for (int f = 0; f < 4; f++)
        run_op(17, 8'(a), 8'h00, {3'b010, f[1], f[0]});
    for (int a = 250; a < 256; a++) run_op(17, 8'(a), 8'h00, 5'b00010);

    for (int i = 0; i < 1500; i++) begin
      run_op(5'($urandom_range(0, 31)), 8'($urandom), 8'($urandom), 5'($urandom));
      if ($urandom_range(0, 9) == 0) idle_cycle();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule